// File: doc/BRIEF.md
# USB OUT Endpoint Packet Bank Controller

This block holds the received data of one USB device OUT endpoint. A simplified receive interface delivers payload bytes and an end-of-packet strobe. The block stores each packet in one of its packet banks, which it fills in turn, and answers every packet with an ACK or NAK handshake one cycle after the end strobe. A parameter selects one bank or two ping-pong banks.

On the CPU side, a small register interface shows the state of the bank the CPU currently owns. It has a packet-received flag, an interrupt enable, a bank-ownership bit, a read-allowed bit and a remaining-byte count. A data port returns the next stored byte on each read. Releasing a bank takes two steps. The CPU first clears the packet-received flag. It then clears the bank-ownership bit, which frees the bank and, in dual-bank mode, moves the CPU to the other bank. The flags are then reloaded from the state of that bank.

Top module: `usb_out_bank_ctrl`

## Requirements
- R1: After reset both banks are empty and bank 0 is current. The control register (address 0) reads 0, the byte count (address 1) reads 0, and `irq` is low.
- R2: When a packet is stored into the CPU's current bank, the packet-received flag (control bit 0) and the bank-ownership bit (control bit 1) are both set.
- R3: `irq` is high exactly while control bit 0 and the interrupt enable (control bit 3, read/write) are both set. With the enable clear, the flags still set and can be polled.
- R4: Writing the control register with bit 0 at 0 clears the packet-received flag. This alone does not release the bank: bit 1 and the byte count are unchanged.
- R5: Writing the control register with bit 1 at 0 releases the current bank, but only if the packet-received flag is already clear. If the flag is still set, the write is ignored. In dual-bank mode a release makes the other bank current. Writing 1 to bit 0 or bit 1 has no effect.
- R6: After a release, bits 0 and 1 are both set if the new current bank holds a packet, and both clear otherwise.
- R7: The read-allowed bit (control bit 2, read-only) is set while the current bank holds unread bytes. It clears once the last byte has been read.
- R8: Address 1 returns the number of unread bytes in the current bank. Each read of address 2 returns the next stored byte in arrival order.
- R9: A read of address 2 while bit 2 is clear returns 0 and leaves the byte count unchanged.
- R10: Banks are filled in alternating order. In single-bank mode, a packet that arrives while the CPU owns the bank gets NAK. In dual-bank mode, a packet goes to the free bank with ACK, and gets NAK only when both banks are occupied.
- R11: A packet longer than `BANK_BYTES` gets NAK, and no bank state changes. A packet of exactly `BANK_BYTES` bytes is accepted.
- R12: `hs_valid` pulses for one cycle, in the cycle after `rx_pkt_end`. `hs_ack` is 1 for ACK and 0 for NAK.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_byte_valid | input | 1 | A payload byte is present on `rx_byte` |
| rx_byte | input | DATA_W | Payload byte |
| rx_pkt_end | input | 1 | End-of-packet strobe |
| hs_valid | output | 1 | Handshake result valid |
| hs_ack | output | 1 | 1 = ACK, 0 = NAK |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops the data port) |
| reg_addr | input | 2 | 0 control, 1 byte count, 2 data port |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, valid in the cycle of the read |
| irq | output | 1 | Packet-received interrupt |

## Verification
The bench tries to release a bank while the packet-received flag is still set. A design that skipped this guard would switch banks early, and the byte count and the next data would belong to the wrong packet. It reads the data port past the end of a bank: a faulty counter would wrap around and replay old bytes. It also sends a packet one byte over the bank size, which a weak length check would accept or partly store. A release onto a bank that already holds a packet must show the flags set again at once. A model that kept them clear would never raise the interrupt for the second packet.

// File: rtl/usb_obk_pkg.sv
package usb_obk_pkg;
   localparam logic [1:0] ADDR_CTRL = 2'd0;
   localparam logic [1:0] ADDR_BCNT = 2'd1;
   localparam logic [1:0] ADDR_DATA = 2'd2;

   localparam int BIT_RXF  = 0;
   localparam int BIT_OWN  = 1;
   localparam int BIT_RDOK = 2;
   localparam int BIT_IE   = 3;

   typedef enum logic {
      HS_NAK = 1'b0,
      HS_ACK = 1'b1
   } hs_code_e;
endpackage

// File: rtl/obk_bank_mem.sv
module obk_bank_mem #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 64,
   parameter int NB     = 2,
   localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic              wr_bank,
   input  logic [AW-1:0]     wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_bank,
   input  logic [AW-1:0]     rd_addr,
   output logic [DATA_W-1:0] rd_data
);
   logic [DATA_W-1:0] bank_q [NB];

   for (genvar b = 0; b < NB; b++) begin : g_bank
      logic [DATA_W-1:0] store [DEPTH];
      always_ff @(posedge clk) begin
         if (wr_en && (wr_bank == 1'(b))) begin
            store[wr_addr] <= wr_data;
         end
      end
      assign bank_q[b] = store[rd_addr];
   end

   if (NB == 2) begin : g_rd_dual
      assign rd_data = rd_bank ? bank_q[1] : bank_q[0];
   end else begin : g_rd_single
      logic unused_rd_bank;
      assign unused_rd_bank = rd_bank;
      assign rd_data = bank_q[0];
   end
endmodule

// File: rtl/obk_rx_side.sv
module obk_rx_side
   import usb_obk_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 64,
   parameter int NB     = 2,
   localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CW    = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pkt_valid,
   input  logic [DATA_W-1:0] pkt_data,
   input  logic              pkt_end,
   input  logic [NB-1:0]     bank_full,
   output logic              wr_en,
   output logic              wr_bank,
   output logic [AW-1:0]     wr_addr,
   output logic [DATA_W-1:0] wr_data,
   output logic              commit,
   output logic              commit_bank,
   output logic [CW-1:0]     commit_len,
   output logic              hs_valid,
   output logic              hs_ack
);
   logic [CW-1:0] len_q;
   logic          drop_q;
   logic          fill_q;
   logic          target_busy;
   logic          too_long;
   logic          byte_drop;
   logic          eff_drop;

   assign target_busy = bank_full[fill_q];
   assign too_long    = (len_q == CW'(DEPTH));
   assign byte_drop   = drop_q | target_busy | too_long;
   assign eff_drop    = drop_q | (pkt_valid & (target_busy | too_long));

   assign wr_en       = pkt_valid & ~byte_drop;
   assign wr_bank     = fill_q;
   assign wr_addr     = len_q[AW-1:0];
   assign wr_data     = pkt_data;

   assign commit      = pkt_end & ~eff_drop & ~target_busy;
   assign commit_bank = fill_q;
   assign commit_len  = len_q + CW'(wr_en);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         len_q    <= '0;
         drop_q   <= 1'b0;
         hs_valid <= 1'b0;
         hs_ack   <= HS_NAK;
      end else if (pkt_end) begin
         len_q    <= '0;
         drop_q   <= 1'b0;
         hs_valid <= 1'b1;
         hs_ack   <= commit ? HS_ACK : HS_NAK;
      end else begin
         hs_valid <= 1'b0;
         if (pkt_valid) begin
            if (byte_drop) drop_q <= 1'b1;
            else           len_q  <= len_q + 1'b1;
         end
      end
   end

   if (NB == 2) begin : g_fill_dual
      always_ff @(posedge clk) begin
         if (!rst_n)      fill_q <= 1'b0;
         else if (commit) fill_q <= ~fill_q;
      end
   end else begin : g_fill_single
      assign fill_q = 1'b0;
   end

   a_r10_busy_nak: assert property (@(posedge clk) disable iff (!rst_n)
      (pkt_end && target_busy) |=> (hs_valid && !hs_ack));
   a_r11_len_bound: assert property (@(posedge clk) disable iff (!rst_n)
      commit |-> (commit_len <= CW'(DEPTH)));
   a_r12_hs_follows_end: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_end |=> hs_valid);
   a_r12_hs_single: assert property (@(posedge clk) disable iff (!rst_n)
      hs_valid |-> $past(pkt_end));
endmodule

// File: rtl/obk_cpu_side.sv
module obk_cpu_side
   import usb_obk_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 64,
   parameter int NB     = 2,
   localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CW    = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              commit,
   input  logic              commit_bank,
   input  logic [CW-1:0]     commit_len,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [1:0]        reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic [NB-1:0]     bank_full,
   output logic              rd_bank,
   output logic [AW-1:0]     rd_addr,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              irq
);
   logic [NB-1:0] full_q, full_n;
   logic [CW-1:0] cnt_q [NB];
   logic [CW-1:0] rd_ptr_q;
   logic          cur_q, cur_n;
   logic          rxf_q, own_q, ie_q;
   logic          wr_ctrl, rxf_clr, rel_req, release_ok;
   logic          rdok, pop;
   logic [CW-1:0] cur_cnt, remaining;
   logic          unused_wbits;

   assign unused_wbits = ^{reg_wdata[DATA_W-1:BIT_IE+1], reg_wdata[BIT_RDOK]};

   assign wr_ctrl    = reg_wr && (reg_addr == ADDR_CTRL);
   assign rxf_clr    = wr_ctrl && !reg_wdata[BIT_RXF];
   assign rel_req    = wr_ctrl && !reg_wdata[BIT_OWN];
   assign release_ok = rel_req && own_q && !rxf_q;

   assign cur_cnt    = cnt_q[cur_q];
   assign remaining  = cur_cnt - rd_ptr_q;
   assign rdok       = full_q[cur_q] && (rd_ptr_q != cur_cnt);
   assign pop        = reg_rd && (reg_addr == ADDR_DATA) && rdok;

   always_comb begin
      full_n = full_q;
      if (commit)     full_n[commit_bank] = 1'b1;
      if (release_ok) full_n[cur_q]       = 1'b0;
   end

   assign cur_n = (NB == 2 && release_ok) ? ~cur_q : cur_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         full_q   <= '0;
         cur_q    <= 1'b0;
         rd_ptr_q <= '0;
         rxf_q    <= 1'b0;
         own_q    <= 1'b0;
         ie_q     <= 1'b0;
         for (int b = 0; b < NB; b++) cnt_q[b] <= '0;
      end else begin
         full_q <= full_n;
         cur_q  <= cur_n;
         if (commit) cnt_q[commit_bank] <= commit_len;
         if (release_ok)  rd_ptr_q <= '0;
         else if (pop)    rd_ptr_q <= rd_ptr_q + 1'b1;
         if (wr_ctrl) ie_q <= reg_wdata[BIT_IE];
         if (release_ok) begin
            rxf_q <= full_n[cur_n];
            own_q <= full_n[cur_n];
         end else if (commit && (commit_bank == cur_q)) begin
            rxf_q <= 1'b1;
            own_q <= 1'b1;
         end else if (rxf_clr) begin
            rxf_q <= 1'b0;
         end
      end
   end

   always_comb begin
      reg_rdata = '0;
      unique case (reg_addr)
         ADDR_CTRL: begin
            reg_rdata[BIT_RXF]  = rxf_q;
            reg_rdata[BIT_OWN]  = own_q;
            reg_rdata[BIT_RDOK] = rdok;
            reg_rdata[BIT_IE]   = ie_q;
         end
         ADDR_BCNT: reg_rdata = full_q[cur_q] ? DATA_W'(remaining) : '0;
         ADDR_DATA: reg_rdata = rdok ? mem_rdata : '0;
         default:   reg_rdata = '0;
      endcase
   end

   assign bank_full = full_q;
   assign rd_bank   = cur_q;
   assign rd_addr   = rd_ptr_q[AW-1:0];
   assign irq       = rxf_q & ie_q;

   a_r2_fill_sets_flags: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && (commit_bank == cur_q)) |=> (rxf_q && own_q));
   a_r5_blocked_release: assert property (@(posedge clk) disable iff (!rst_n)
      (rel_req && rxf_q) |=> $stable(cur_q));
   a_r7_rdok_owned: assert property (@(posedge clk) disable iff (!rst_n)
      rdok |-> own_q);
   a_r9_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd && (reg_addr == ADDR_DATA) && !rdok && !reg_wr) |=> $stable(rd_ptr_q));
   a_r4_ack_keeps_bank: assert property (@(posedge clk) disable iff (!rst_n)
      (rxf_clr && !rel_req && !commit) |=> $stable(full_q));
endmodule

// File: rtl/usb_out_bank_ctrl.sv
module usb_out_bank_ctrl #(
   parameter int DATA_W     = 8,
   parameter int BANK_BYTES = 64,
   parameter bit DUAL_BANK  = 1'b1,
   localparam int NB        = DUAL_BANK ? 2 : 1,
   localparam int AW        = (BANK_BYTES > 1) ? $clog2(BANK_BYTES) : 1,
   localparam int CW        = $clog2(BANK_BYTES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_byte_valid,
   input  logic [DATA_W-1:0] rx_byte,
   input  logic              rx_pkt_end,
   output logic              hs_valid,
   output logic              hs_ack,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [1:0]        reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              irq
);
   initial begin
      a_param_bank: assert (BANK_BYTES >= 2)
         else $error("BANK_BYTES must be at least 2");
      a_param_width: assert (DATA_W >= 4 && CW <= DATA_W)
         else $error("DATA_W too narrow for flags or byte count");
   end

   logic [NB-1:0]     bank_full;
   logic              wr_en, wr_bank, commit, commit_bank, rd_bank;
   logic [AW-1:0]     wr_addr, rd_addr;
   logic [DATA_W-1:0] wr_data, mem_rdata;
   logic [CW-1:0]     commit_len;

   obk_rx_side #(.DATA_W(DATA_W), .DEPTH(BANK_BYTES), .NB(NB)) u_rx (
      .clk         (clk),
      .rst_n       (rst_n),
      .pkt_valid   (rx_byte_valid),
      .pkt_data    (rx_byte),
      .pkt_end     (rx_pkt_end),
      .bank_full   (bank_full),
      .wr_en       (wr_en),
      .wr_bank     (wr_bank),
      .wr_addr     (wr_addr),
      .wr_data     (wr_data),
      .commit      (commit),
      .commit_bank (commit_bank),
      .commit_len  (commit_len),
      .hs_valid    (hs_valid),
      .hs_ack      (hs_ack)
   );

   obk_bank_mem #(.DATA_W(DATA_W), .DEPTH(BANK_BYTES), .NB(NB)) u_mem (
      .clk     (clk),
      .wr_en   (wr_en),
      .wr_bank (wr_bank),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .rd_bank (rd_bank),
      .rd_addr (rd_addr),
      .rd_data (mem_rdata)
   );

   obk_cpu_side #(.DATA_W(DATA_W), .DEPTH(BANK_BYTES), .NB(NB)) u_cpu (
      .clk         (clk),
      .rst_n       (rst_n),
      .commit      (commit),
      .commit_bank (commit_bank),
      .commit_len  (commit_len),
      .reg_wr      (reg_wr),
      .reg_rd      (reg_rd),
      .reg_addr    (reg_addr),
      .reg_wdata   (reg_wdata),
      .mem_rdata   (mem_rdata),
      .bank_full   (bank_full),
      .rd_bank     (rd_bank),
      .rd_addr     (rd_addr),
      .reg_rdata   (reg_rdata),
      .irq         (irq)
   );
endmodule

// File: tb/test_usb_out_bank_ctrl.sv
`timescale 1ns/1ps
module test_usb_out_bank_ctrl;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       pv [2];
   logic       pe [2];
   logic [7:0] pd [2];
   logic       hv [2];
   logic       ha [2];
   logic       rw [2];
   logic       rr [2];
   logic [1:0] ra [2];
   logic [7:0] wd [2];
   logic [7:0] rdv [2];
   logic       irq [2];

   int checks = 0;
   int fails  = 0;
   logic [7:0] exp_d0 [$];
   logic [7:0] exp_d1 [$];
   logic       exp_h0 [$];
   logic       exp_h1 [$];

   always #10 clk = ~clk;

   usb_out_bank_ctrl #(.BANK_BYTES(64), .DUAL_BANK(1'b1)) i_usb_out_bank_ctrl (
      .clk(clk), .rst_n(rst_n), .rx_byte_valid(pv[0]), .rx_byte(pd[0]),
      .rx_pkt_end(pe[0]), .hs_valid(hv[0]), .hs_ack(ha[0]), .reg_wr(rw[0]),
      .reg_rd(rr[0]), .reg_addr(ra[0]), .reg_wdata(wd[0]), .reg_rdata(rdv[0]),
      .irq(irq[0]));

   usb_out_bank_ctrl #(.BANK_BYTES(64), .DUAL_BANK(1'b0)) i_usb_out_bank_ctrl_single (
      .clk(clk), .rst_n(rst_n), .rx_byte_valid(pv[1]), .rx_byte(pd[1]),
      .rx_pkt_end(pe[1]), .hs_valid(hv[1]), .hs_ack(ha[1]), .reg_wr(rw[1]),
      .reg_rd(rr[1]), .reg_addr(ra[1]), .reg_wdata(wd[1]), .reg_rdata(rdv[1]),
      .irq(irq[1]));

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Handshake monitor: pops expected handshakes (R10 R11 R12)
   always @(negedge clk) begin
      if (rst_n) begin
         for (int u = 0; u < 2; u++) begin
            if (hv[u]) begin
               logic e;
               if (u == 0 && exp_h0.size() > 0)      e = exp_h0.pop_front();
               else if (u == 1 && exp_h1.size() > 0) e = exp_h1.pop_front();
               else begin
                  check(1'b0, "R12 unexpected handshake", 1, 0);
                  continue;
               end
               check(ha[u] == e, "R10 R11 R12 handshake", int'(ha[u]), int'(e));
            end
         end
      end
   end

   task automatic send_pkt(input int u, input int len, input logic [7:0] seed, input bit ack);
      for (int i = 0; i < len; i++) begin
         @(negedge clk);
         pv[u] = 1'b1;
         pd[u] = seed + 8'(i);
      end
      @(negedge clk);
      pv[u] = 1'b0;
      pe[u] = 1'b1;
      if (u == 0) exp_h0.push_back(ack); else exp_h1.push_back(ack);
      if (ack) begin
         for (int i = 0; i < len; i++) begin
            if (u == 0) exp_d0.push_back(seed + 8'(i));
            else        exp_d1.push_back(seed + 8'(i));
         end
      end
      @(negedge clk);
      pe[u] = 1'b0;
      @(negedge clk);
   endtask

   task automatic cpu_wr(input int u, input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      rw[u] = 1'b1; ra[u] = a; wd[u] = d;
      @(negedge clk);
      rw[u] = 1'b0;
   endtask

   task automatic cpu_rd(input int u, input logic [1:0] a, output logic [7:0] v);
      @(negedge clk);
      rr[u] = 1'b1; ra[u] = a;
      #1 v = rdv[u];
      @(negedge clk);
      rr[u] = 1'b0;
   endtask

   task automatic chk_ctrl(input int u, input logic [7:0] e, input string req);
      logic [7:0] v;
      cpu_rd(u, 2'd0, v);
      check(v == e, req, int'(v), int'(e));
   endtask

   task automatic chk_cnt(input int u, input logic [7:0] e, input string req);
      logic [7:0] v;
      cpu_rd(u, 2'd1, v);
      check(v == e, req, int'(v), int'(e));
   endtask

   task automatic pop_data(input int u, input int n, input string req);
      for (int i = 0; i < n; i++) begin
         logic [7:0] v, e;
         cpu_rd(u, 2'd2, v);
         if (u == 0) e = (exp_d0.size() > 0) ? exp_d0.pop_front() : 8'hxx;
         else        e = (exp_d1.size() > 0) ? exp_d1.pop_front() : 8'hxx;
         check(v === e, req, int'(v), int'(e));
      end
   endtask

   initial begin
      #(20 * 100000);
      check(1'b0, "watchdog expired", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      logic [7:0] v;
      for (int u = 0; u < 2; u++) begin
         pv[u] = 0; pe[u] = 0; pd[u] = 0; rw[u] = 0; rr[u] = 0; ra[u] = 0; wd[u] = 0;
      end
      repeat (5) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      chk_ctrl(0, 8'h00, "R1 ctrl after reset");
      chk_cnt(0, 8'h00, "R1 count after reset");
      check(irq[0] == 1'b0, "R1 irq after reset", int'(irq[0]), 0);

      // Dual bank: enable interrupt, writing 1 to flag bits has no effect (R5)
      cpu_wr(0, 2'd0, 8'h0B);
      chk_ctrl(0, 8'h08, "R5 ones to flags do nothing");
      send_pkt(0, 5, 8'h10, 1'b1);
      chk_ctrl(0, 8'h0F, "R2 flags set on fill");
      check(irq[0] == 1'b1, "R3 irq with enable", int'(irq[0]), 1);
      chk_cnt(0, 8'd5, "R8 byte count");
      send_pkt(0, 3, 8'h40, 1'b1);   // R10 free second bank ACK
      send_pkt(0, 2, 8'h70, 1'b0);   // R10 both banks busy NAK
      chk_ctrl(0, 8'h0F, "R10 flags unchanged by second bank");

      // R5 release with flag still set is ignored
      cpu_wr(0, 2'd0, 8'h09);
      chk_ctrl(0, 8'h0F, "R5 blocked release");
      chk_cnt(0, 8'd5, "R5 blocked release count");

      // R4 acknowledge does not release
      cpu_wr(0, 2'd0, 8'h0A);
      chk_ctrl(0, 8'h0E, "R4 ack keeps bank");
      check(irq[0] == 1'b0, "R3 irq drops on ack", int'(irq[0]), 0);
      chk_cnt(0, 8'd5, "R4 count kept");

      pop_data(0, 2, "R8 data order");
      chk_cnt(0, 8'd3, "R8 count decrements");
      pop_data(0, 3, "R8 data order tail");
      chk_ctrl(0, 8'h0A, "R7 read-allowed cleared");
      cpu_rd(0, 2'd2, v);
      check(v == 8'h00, "R9 empty read returns zero", int'(v), 0);
      chk_cnt(0, 8'd0, "R9 count unchanged");

      // R6 release onto a full bank
      cpu_wr(0, 2'd0, 8'h08);
      chk_ctrl(0, 8'h0F, "R6 flags reload set");
      chk_cnt(0, 8'd3, "R6 new bank count");

      // R11 oversize NAK, exact size ACK
      send_pkt(0, 65, 8'h90, 1'b0);
      chk_ctrl(0, 8'h0F, "R11 oversize leaves state");
      chk_cnt(0, 8'd3, "R11 oversize leaves count");
      send_pkt(0, 64, 8'hA0, 1'b1);

      cpu_wr(0, 2'd0, 8'h0A);
      pop_data(0, 3, "R8 second bank data");
      cpu_wr(0, 2'd0, 8'h08);
      chk_ctrl(0, 8'h0F, "R6 switch back to full bank");
      chk_cnt(0, 8'd64, "R11 exact-size count");
      cpu_wr(0, 2'd0, 8'h0A);
      pop_data(0, 64, "R11 exact-size data");
      cpu_wr(0, 2'd0, 8'h08);
      chk_ctrl(0, 8'h08, "R6 flags reload clear");
      chk_cnt(0, 8'd0, "R6 empty bank count");

      // R3 polled mode with enable clear
      cpu_wr(0, 2'd0, 8'h00);
      send_pkt(0, 4, 8'hC0, 1'b1);
      chk_ctrl(0, 8'h07, "R3 poll flags");
      check(irq[0] == 1'b0, "R3 no irq without enable", int'(irq[0]), 0);
      cpu_wr(0, 2'd0, 8'h02);
      pop_data(0, 4, "R8 polled data");
      cpu_wr(0, 2'd0, 8'h00);
      chk_ctrl(0, 8'h00, "R5 release in polled mode");

      // Single bank
      chk_ctrl(1, 8'h00, "R1 single reset");
      send_pkt(1, 3, 8'h20, 1'b1);
      send_pkt(1, 2, 8'h30, 1'b0);   // R10 owned bank NAK
      chk_ctrl(1, 8'h07, "R2 single flags");
      cpu_wr(1, 2'd0, 8'h02);
      pop_data(1, 3, "R8 single data");
      cpu_wr(1, 2'd0, 8'h00);
      chk_ctrl(1, 8'h00, "R6 single release clears");
      send_pkt(1, 2, 8'h50, 1'b1);   // R10 ACK after release
      chk_ctrl(1, 8'h07, "R10 single refill");
      cpu_wr(1, 2'd0, 8'h02);
      pop_data(1, 2, "R8 single refill data");

      repeat (4) @(negedge clk);
      check(exp_h0.size() == 0 && exp_h1.size() == 0, "R12 all handshakes seen",
            exp_h0.size() + exp_h1.size(), 0);
      check(exp_d0.size() == 0 && exp_d1.size() == 0, "R8 all data read",
            exp_d0.size() + exp_d1.size(), 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule